// File: doc/BRIEF.md
# Split Floating-Point Status Register Update Unit

This block keeps a 64-bit floating-point status and control word as three independently stored parts: the per-operation result flags (volatile part), the accumulating exception bits (sticky part) and the mode and enable bits (control part). Each cycle it may accept the outcome of one finished floating-point operation. The outcome carries new class and rounding flags, the exception causes the operation raised, and the 16-bit sticky image that the operation read when it started.

The block overwrites the volatile part, ORs the raised causes into the sticky part, and recomputes the invalid summary, the enabled summary and the any-new-exception flag. Operations start from the stored sticky value, which is on `sticky_o`, and do not wait for the previous operation's result. When the merged sticky image differs from the image an operation assumed, the block pulses `replay_o` so that younger operations are cancelled and reissued. Software can rewrite the control part, and the whole word can be read at any time on `fpscr_o`.

Top module: `fpsr_split_unit`

## Requirements
- R1: After reset `fpscr_o`, `sticky_o` and `replay_o` are all zero. This selects round-to-nearest-even (RN code 00) with every exception disabled.
- R2: A result (`res_valid`=1) overwrites word bit 18 (fraction rounded) with `res_fr`, bit 17 (fraction inexact) with `res_fi`, and bits 16:12 with `res_fprf`. The new values are visible the cycle after the result. Without a result these bits hold.
- R3: Raised causes `res_exc[i]` are ORed into the word, and no cause bit ever clears. The cause index maps to a word bit as follows: 0 bad integer convert→8, 1 bad square root→9, 2 software invalid→10, 3 invalid compare→19, 4 inf×0→20, 5 0/0→21, 6 inf/inf→22, 7 inf−inf→23, 8 signalling NaN→24, 9 inexact→25, 10 divide by zero→26, 11 underflow→27, 12 overflow→28.
- R4: Word bit 29 (invalid summary) equals the OR of causes 0 to 8.
- R5: Word bit 30 (enabled summary) equals (invalid summary & bit 7) | (overflow & bit 6) | (underflow & bit 5) | (zero divide & bit 4) | (inexact & bit 3). It is recomputed after every result merge and after every control write.
- R6: Word bit 31 (exception summary) becomes 1 when a result sets a cause bit that was 0 before. It is never cleared. A result that raises no cause leaves it at 0 if it was 0.
- R7: `replay_o` is 1 for exactly the cycle after a result whose merged 16-bit sticky image differs from `res_sticky_seen`. It is 0 otherwise. The sticky image packs causes 0 to 12 into bits 12:0, the invalid summary into bit 13, the enabled summary into bit 14 and the exception summary into bit 15.
- R8: A software write (`sw_wr`=1) replaces only the control bits with `sw_data`. The control bits are 7:0, 11 and 63:32, which include RN at 1:0 and the enables at 7:3. No other word bit changes.
- R9: When a result and a software write arrive in the same cycle, the result is merged first and the write is then applied. The control bits come from `sw_data`, the volatile and cause bits come from the result, and the enabled summary uses the newly written enables.
- R10: `sticky_o` always equals the sticky image (R7 packing) of the current word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | A completed FP operation's outcome is present |
| res_fprf | input | 5 | Result class and condition flags |
| res_fr | input | 1 | Fraction rounded flag |
| res_fi | input | 1 | Fraction inexact flag |
| res_exc | input | 13 | Raised exception causes, indexed as in R3 |
| res_sticky_seen | input | 16 | Sticky image the operation assumed |
| sw_wr | input | 1 | Software control-part write strobe |
| sw_data | input | 64 | Software write data, only control bits used |
| fpscr_o | output | 64 | Full status and control word |
| sticky_o | output | 16 | Current sticky image for issuing operations |
| replay_o | output | 1 | Cancel and retry request for younger operations |

## Verification
A result merge and a software control write can land in the same cycle. The bench provokes this by driving both strobes together while the raised cause needs an enable that the write turns on, or that it turns off. The bench then checks that the control bits equal the written data, that the flags come from the result, and that the enabled summary and the replay pulse follow the new enables. Both are compared against a bench model of the whole word.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;

    localparam int WORD_W  = 64;
    localparam int NCAUSE  = 13;
    localparam int NINV    = 9;
    localparam int FPRF_W  = 5;
    localparam int STK_W   = NCAUSE + 3;

    localparam int POS_FPRF_LO = 12;
    localparam int POS_FI      = 17;
    localparam int POS_FR      = 18;
    localparam int POS_VX      = 29;
    localparam int POS_FEX     = 30;
    localparam int POS_FX      = 31;
    localparam int POS_VE      = 7;
    localparam int POS_OE      = 6;
    localparam int POS_UE      = 5;
    localparam int POS_ZE      = 4;
    localparam int POS_XE      = 3;

    localparam int C_XX = 9;
    localparam int C_ZX = 10;
    localparam int C_UX = 11;
    localparam int C_OX = 12;

    localparam logic [WORD_W-1:0] CTRL_MASK = 64'hFFFF_FFFF_0000_08FF;

    typedef struct packed {
        logic              fx;
        logic              fex;
        logic              vx;
        logic [NCAUSE-1:0] cause;
    } sticky_t;

    typedef struct packed {
        logic              fr;
        logic              fi;
        logic [FPRF_W-1:0] fprf;
    } vol_t;

    typedef struct packed {
        logic ve;
        logic oe;
        logic ue;
        logic ze;
        logic xe;
    } enab_t;

    function automatic int cause_pos(input int idx);
        return (idx < 3) ? (8 + idx) : (16 + idx);
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(
        input vol_t v, input sticky_t s, input logic [WORD_W-1:0] c);
        logic [WORD_W-1:0] w;
        w = c & CTRL_MASK;
        w[POS_FR] = v.fr;
        w[POS_FI] = v.fi;
        w[POS_FPRF_LO +: FPRF_W] = v.fprf;
        for (int i = 0; i < NCAUSE; i++) begin
            w[cause_pos(i)] = s.cause[i];
        end
        w[POS_VX]  = s.vx;
        w[POS_FEX] = s.fex;
        w[POS_FX]  = s.fx;
        return w;
    endfunction

endpackage

// File: rtl/fpsr_ctrl_filter.sv
module fpsr_ctrl_filter
    import fpsr_pkg::*;
(
    input  logic [WORD_W-1:0] ctrl_cur,
    input  logic              sw_wr,
    input  logic [WORD_W-1:0] sw_data,
    output logic [WORD_W-1:0] ctrl_nxt,
    output enab_t             enab
);
    always_comb begin
        ctrl_nxt = sw_wr ? (sw_data & CTRL_MASK) : ctrl_cur;
        enab.ve  = ctrl_nxt[POS_VE];
        enab.oe  = ctrl_nxt[POS_OE];
        enab.ue  = ctrl_nxt[POS_UE];
        enab.ze  = ctrl_nxt[POS_ZE];
        enab.xe  = ctrl_nxt[POS_XE];
    end
endmodule

// File: rtl/fpsr_sticky_merge.sv
module fpsr_sticky_merge
    import fpsr_pkg::*;
(
    input  sticky_t           cur,
    input  logic              raise_en,
    input  logic [NCAUSE-1:0] raise,
    input  enab_t             enab,
    output sticky_t           nxt
);
    logic [NCAUSE-1:0] raise_m;
    logic [NCAUSE-1:0] fresh;

    always_comb begin
        raise_m   = raise_en ? raise : '0;
        fresh     = raise_m & ~cur.cause;
        nxt.cause = cur.cause | raise_m;
        nxt.vx    = |nxt.cause[NINV-1:0];
        nxt.fex   = (nxt.vx          & enab.ve) |
                    (nxt.cause[C_OX] & enab.oe) |
                    (nxt.cause[C_UX] & enab.ue) |
                    (nxt.cause[C_ZX] & enab.ze) |
                    (nxt.cause[C_XX] & enab.xe);
        nxt.fx    = cur.fx | (|fresh);
    end
endmodule

// File: rtl/fpsr_split_unit.sv
module fpsr_split_unit
    import fpsr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  res_valid,
    input  logic [FPRF_W-1:0]     res_fprf,
    input  logic                  res_fr,
    input  logic                  res_fi,
    input  logic [NCAUSE-1:0]     res_exc,
    input  logic [STK_W-1:0]      res_sticky_seen,
    input  logic                  sw_wr,
    input  logic [WORD_W-1:0]     sw_data,
    output logic [WORD_W-1:0]     fpscr_o,
    output logic [STK_W-1:0]      sticky_o,
    output logic                  replay_o
);
    typedef struct packed {
        vol_t              vol;
        sticky_t           stk;
        logic [WORD_W-1:0] ctrl;
        logic              replay;
    } state_t;

    state_t            st_d, st_q;
    logic [WORD_W-1:0] ctrl_nxt;
    enab_t             enab;
    sticky_t           stk_merged;

    fpsr_ctrl_filter u_ctrl (
        .ctrl_cur (st_q.ctrl),
        .sw_wr    (sw_wr),
        .sw_data  (sw_data),
        .ctrl_nxt (ctrl_nxt),
        .enab     (enab)
    );

    fpsr_sticky_merge u_merge (
        .cur      (st_q.stk),
        .raise_en (res_valid),
        .raise    (res_exc),
        .enab     (enab),
        .nxt      (stk_merged)
    );

    always_comb begin
        st_d        = st_q;
        st_d.ctrl   = ctrl_nxt;
        st_d.stk    = stk_merged;
        st_d.replay = 1'b0;
        if (res_valid) begin
            st_d.vol.fr   = res_fr;
            st_d.vol.fi   = res_fi;
            st_d.vol.fprf = res_fprf;
            st_d.replay   = (stk_merged != sticky_t'(res_sticky_seen));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fpscr_o  = pack_word(st_q.vol, st_q.stk, st_q.ctrl);
    assign sticky_o = st_q.stk;
    assign replay_o = st_q.replay;

    AST_VX_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        fpscr_o[POS_VX] == (|st_q.stk.cause[NINV-1:0]));                         // R4
    AST_CAUSE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.stk.cause & $past(st_q.stk.cause)) == $past(st_q.stk.cause))); // R3
    AST_FX_ON_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && ((res_exc & ~st_q.stk.cause) != '0)) |=> fpscr_o[POS_FX]);  // R6
    AST_REPLAY_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        replay_o |-> $past(res_valid));                                           // R7
    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_wr |=> ((fpscr_o & CTRL_MASK) == $past(fpscr_o & CTRL_MASK)));       // R8
    AST_VOL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(fpscr_o[POS_FR:POS_FPRF_LO]));                     // R2
    AST_STICKY_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        sticky_o[STK_W-1] == fpscr_o[POS_FX]);                                    // R10

endmodule

// File: tb/sim_fpsr_split_unit.sv
module sim_fpsr_split_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        res_valid;
    logic [4:0]  res_fprf;
    logic        res_fr, res_fi;
    logic [12:0] res_exc;
    logic [15:0] res_sticky_seen;
    logic        sw_wr;
    logic [63:0] sw_data;
    logic [63:0] fpscr_o;
    logic [15:0] sticky_o;
    logic        replay_o;

    int checks = 0;
    int fails  = 0;
    logic [63:0] exp_w;
    logic        exp_rp;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpsr_split_unit u0 (.*);

    function automatic int cpos(input int i);
        int p [13] = '{8, 9, 10, 19, 20, 21, 22, 23, 24, 25, 26, 27, 28};
        return p[i];
    endfunction

    function automatic logic [15:0] stk_img(input logic [63:0] w);
        logic [15:0] s;
        for (int i = 0; i < 13; i++) s[i] = w[cpos(i)];
        s[13] = w[29]; s[14] = w[30]; s[15] = w[31];
        return s;
    endfunction

    // bench model of one cycle, built from R2..R9
    task automatic model(input logic v, input logic [4:0] fprf, input logic fr, input logic fi,
                         input logic [12:0] exc, input logic [15:0] seen,
                         input logic sw, input logic [63:0] d);
        logic [63:0] n;
        logic anyinv;
        n = exp_w;
        if (v) begin
            n[18] = fr; n[17] = fi; n[16:12] = fprf;
            for (int i = 0; i < 13; i++)
                if (exc[i]) begin
                    if (!n[cpos(i)]) n[31] = 1'b1;
                    n[cpos(i)] = 1'b1;
                end
        end
        if (sw) n = (n & ~64'hFFFF_FFFF_0000_08FF) | (d & 64'hFFFF_FFFF_0000_08FF);
        anyinv = 1'b0;
        for (int i = 0; i < 9; i++) anyinv |= n[cpos(i)];
        n[29] = anyinv;
        n[30] = (n[29] & n[7]) | (n[28] & n[6]) | (n[27] & n[5]) | (n[26] & n[4]) | (n[25] & n[3]);
        exp_rp = v && (stk_img(n) != seen);
        exp_w  = n;
    endtask

    task automatic chk(input string req);
        checks += 3;
        if (fpscr_o !== exp_w) begin
            fails++; $display("FAIL %s fpscr act=%h exp=%h", req, fpscr_o, exp_w);
        end
        if (replay_o !== exp_rp) begin
            fails++; $display("FAIL %s replay act=%b exp=%b", req, replay_o, exp_rp);
        end
        if (sticky_o !== stk_img(exp_w)) begin
            fails++; $display("FAIL %s R10 sticky act=%h exp=%h", req, sticky_o, stk_img(exp_w));
        end
    endtask

    task automatic step(input string req, input logic v, input logic [4:0] fprf,
                        input logic fr, input logic fi, input logic [12:0] exc,
                        input logic [15:0] seen, input logic sw, input logic [63:0] d);
        @(negedge clk);
        res_valid = v; res_fprf = fprf; res_fr = fr; res_fi = fi;
        res_exc = exc; res_sticky_seen = seen; sw_wr = sw; sw_data = d;
        model(v, fprf, fr, fi, exc, seen, sw, d);
        @(negedge clk);
        chk(req);
        res_valid = 0; sw_wr = 0; res_exc = '0;
    endtask

    task automatic idle(input string req);
        step(req, 0, 5'h1F, 1, 1, 13'h1FFF, 16'h0, 0, '1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; res_valid = 0; sw_wr = 0; res_exc = '0;
        res_fprf = '0; res_fr = 0; res_fi = 0; res_sticky_seen = '0; sw_data = '0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        exp_w = '0; exp_rp = 0;
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk("R1");
    endtask

    task automatic t_volatile();
        do_reset();
        step("R2", 1, 5'b10010, 1, 0, '0, 16'h0, 0, '0);
        idle("R2 hold");
        step("R2", 1, 5'b01000, 0, 1, '0, 16'h0, 0, '0);
    endtask

    task automatic t_sticky();
        do_reset();
        step("R3 R6 R7", 1, 5'h0, 0, 0, 13'h1000, 16'h0, 0, '0);      // overflow, stale
        step("R3 R7 noreplay", 1, 5'h0, 0, 0, '0, stk_img(exp_w), 0, '0);
        step("R3 R4", 1, 5'h0, 0, 0, 13'h0100, stk_img(exp_w), 0, '0); // SNaN
        idle("R3 hold");
        step("R4", 1, 5'h0, 0, 0, 13'h0008, stk_img(exp_w), 0, '0);    // compare
    endtask

    task automatic t_fx();
        do_reset();
        step("R6 none", 1, 5'h3, 0, 0, '0, 16'h0, 0, '0);
        step("R6 new", 1, 5'h3, 0, 0, 13'h0200, 16'h0, 0, '0);
    endtask

    task automatic t_fex();
        do_reset();
        step("R5", 1, 5'h0, 0, 0, 13'h0002, 16'h0, 0, '0);
        step("R5 ve", 0, 5'h0, 0, 0, '0, 16'h0, 1, 64'h80);
        do_reset();
        step("R5 oe", 0, 5'h0, 0, 0, '0, 16'h0, 1, 64'h40);
        step("R5 ux", 1, 5'h0, 0, 0, 13'h0800, 16'h0, 0, '0);
        step("R5 ox", 1, 5'h0, 0, 0, 13'h1000, stk_img(exp_w), 0, '0);
    endtask

    task automatic t_ctrl();
        do_reset();
        step("R8", 1, 5'h15, 1, 1, 13'h0400, 16'h0, 0, '0);
        step("R8 all", 0, 5'h0, 0, 0, '0, 16'h0, 1, '1);
        step("R8 rn", 0, 5'h0, 0, 0, '0, 16'h0, 1, 64'h0000_0005_0000_0003);
    endtask

    task automatic t_collide();
        do_reset();
        step("R9 on", 1, 5'h4, 1, 0, 13'h0400, 16'h0, 1, 64'h10);
        step("R9 off", 1, 5'h2, 0, 1, 13'h0001, stk_img(exp_w) | 16'h0001 | 16'h2000, 1, 64'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_volatile();
        t_sticky();
        t_fx();
        t_fex();
        t_ctrl();
        t_collide();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule